// File: doc/BRIEF.md
# Serial Bootstrap Entry Autobaud Detector

This block decides when the device has been placed in serial program-load mode and then finds the bit rate a host is using on the receive line. Load mode requires three things at the same time: the reset-level input is high, the active-low program-strobe input is low, and both high-address port bits are high. If either address bit is low, the strap selects parallel loading, and this block stays out of the way.

While load mode holds, the detector waits for the host to send one carriage-return character (0x0D). It times the start bit and matches that width against four candidate rates: 9600, 2400, 1200 and 300 bps, each with a ±5% window. It then samples every data bit and the stop bit at the middle of each bit, using the measured width. Only a full, correctly framed carriage return produces a lock. The lock publishes a rate index and the nominal clock-cycles-per-bit divisor for a downstream UART. Both values stay frozen until load mode ends.

The three-wire link has no handshake. The receive line is the only timing source.

Top module: `abd_top`

## Requirements
- R1: `load_mode_o` rises one clock after `rst_lvl_i`=1, `strobe_n_i`=0 and `addr_hi_i`=2'b11 are all present. It falls one clock after any of these conditions goes away.
- R2: When either bit of `addr_hi_i` is 0, `load_mode_o` stays 0. A carriage return sent in that state gives no lock.
- R3: Rate index encoding is 0 for 9600, 1 for 2400, 2 for 1200 and 3 for 300 bps. On lock, `divisor_o` equals CLK_HZ divided by the locked rate, with the integer part kept.
- R4: A start bit is accepted for a rate when its low time in clocks lies in [N − N/20, N + N/20], where N is that rate's divisor and the division is integer. A start width outside every window gives no lock.
- R5: Lock requires the LSB-first bit sequence 1,0,1,1,0,0,0,0 after the start bit. Any other character gives no lock.
- R6: A low stop bit discards the candidate. A later valid frame still locks.
- R7: After lock, `rate_idx_o` and `divisor_o` do not change under further traffic, even at another rate, while load mode holds.
- R8: Leaving load mode clears `locked_o`, `rate_idx_o` and `divisor_o` to 0 one clock after `load_mode_o` falls.
- R9: After the synchronous reset `rst`, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_lvl_i | input | 1 | Level of the device reset pin (high requests load) |
| strobe_n_i | input | 1 | Active-low program-store strobe |
| addr_hi_i | input | 2 | Upper port address bits 7 and 6 (index 1 = bit 7) |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| load_mode_o | output | 1 | Serial program-load mode is active |
| locked_o | output | 1 | A carriage return was recognised and the rate is fixed |
| rate_idx_o | output | 2 | Locked rate index (see R3) |
| divisor_o | output | CNT_W | Clock cycles per bit for the locked rate |

## Verification
The detector's state machine is hidden; its only visible sign is whether `locked_o` rises after a frame, and with which index and divisor. A wrong width classification or a wrong bit-pattern check shows up within one character time: the lock is missing, is falsely granted, or carries the index of a neighbouring rate. A state that is not cleared on leaving load mode shows one clock after `load_mode_o` falls, as a non-zero index or divisor. Bit periods near the edges of the acceptance window, and frames with bad data or a bad stop bit, expose sampling-phase errors long before normal traffic would.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam int unsigned NUM_RATES = 4;
    localparam int unsigned RATE_W    = $clog2(NUM_RATES);
    localparam logic [7:0]  CR_CHAR   = 8'h0D;
    localparam int unsigned LAST_BIT  = 8;   // index of the stop-bit sample

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_LOCK  = 2'd3
    } abd_state_e;

    typedef struct packed {
        logic              hit;
        logic [RATE_W-1:0] idx;
    } rate_match_t;

    // Candidate bit rates in index order, fastest first.
    function automatic int unsigned baud_of(input int unsigned idx);
        case (idx)
            0:       return 9600;
            1:       return 2400;
            2:       return 1200;
            default: return 300;
        endcase
    endfunction

    function automatic int unsigned nominal_cycles(input int unsigned clk_hz,
                                                   input int unsigned idx);
        return clk_hz / baud_of(idx);
    endfunction

    function automatic int unsigned window_lo(input int unsigned clk_hz,
                                              input int unsigned idx);
        int unsigned n;
        n = nominal_cycles(clk_hz, idx);
        return n - n / 20;
    endfunction

    function automatic int unsigned window_hi(input int unsigned clk_hz,
                                              input int unsigned idx);
        int unsigned n;
        n = nominal_cycles(clk_hz, idx);
        return n + n / 20;
    endfunction

endpackage

// File: rtl/abd_rx_sync.sv
module abd_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    output logic rx_o,
    output logic fall_o
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
        end else begin
            shreg <= {shreg[STAGES-1:0], rxd_i};
        end
    end

    assign rx_o   = shreg[STAGES-1];
    assign fall_o = shreg[STAGES] & ~shreg[STAGES-1];

endmodule

// File: rtl/abd_entry.sv
module abd_entry (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_lvl_i,
    input  logic       strobe_n_i,
    input  logic [1:0] addr_hi_i,
    output logic       load_o
);
    logic load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b0;
        end else begin
            load_q <= rst_lvl_i & ~strobe_n_i & (&addr_hi_i);
        end
    end

    assign load_o = load_q;

    // R2: a parallel-load strap never yields serial load mode
    p_parallel_block_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_hi_i != 2'b11) |=> !load_o);

endmodule

// File: rtl/abd_classify.sv
module abd_classify
    import abd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 12_000_000,
    parameter int unsigned CNT_W  = 16
) (
    input  logic [CNT_W-1:0] width_i,
    output rate_match_t      match_o
);
    logic [NUM_RATES-1:0] hit;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
        localparam int unsigned LO = window_lo(CLK_HZ, g);
        localparam int unsigned HI = window_hi(CLK_HZ, g);
        assign hit[g] = (width_i >= CNT_W'(LO)) && (width_i <= CNT_W'(HI));
    end

    always_comb begin
        match_o.hit = |hit;
        match_o.idx = '0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (hit[i]) match_o.idx = RATE_W'(i);
        end
        // R4: the tolerance windows never overlap
        p_disjoint_windows_r4: assert ($onehot0(hit));
    end

endmodule

// File: rtl/abd_top.sv
module abd_top
    import abd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 12_000_000,
    localparam int unsigned CNT_W = $clog2(window_hi(CLK_HZ, NUM_RATES - 1) + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_lvl_i,
    input  logic              strobe_n_i,
    input  logic [1:0]        addr_hi_i,
    input  logic              rxd_i,
    output logic              load_mode_o,
    output logic              locked_o,
    output logic [RATE_W-1:0] rate_idx_o,
    output logic [CNT_W-1:0]  divisor_o
);
    localparam int unsigned MAX_HI = window_hi(CLK_HZ, NUM_RATES - 1);

    logic        load_q;
    logic        rx_s;
    logic        rx_fall;
    rate_match_t match;

    abd_entry u_entry (
        .clk        (clk),
        .rst        (rst),
        .rst_lvl_i  (rst_lvl_i),
        .strobe_n_i (strobe_n_i),
        .addr_hi_i  (addr_hi_i),
        .load_o     (load_q)
    );

    abd_rx_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rxd_i  (rxd_i),
        .rx_o   (rx_s),
        .fall_o (rx_fall)
    );

    abd_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  width_q;
    logic [CNT_W-1:0]  tmr_q;
    logic [3:0]        bitn_q;
    logic [RATE_W-1:0] cand_q;
    logic [RATE_W-1:0] idx_q;
    logic [CNT_W-1:0]  div_q;
    logic              locked_q;

    abd_classify #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_cls (
        .width_i (cnt_q),
        .match_o (match)
    );

    logic [CNT_W-1:0] nom_tab [NUM_RATES];
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_nom
        assign nom_tab[g] = CNT_W'(nominal_cycles(CLK_HZ, g));
    end

    always_ff @(posedge clk) begin
        if (rst || !load_q) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            width_q  <= '0;
            tmr_q    <= '0;
            bitn_q   <= '0;
            cand_q   <= '0;
            idx_q    <= '0;
            div_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (rx_fall) begin
                        cnt_q   <= CNT_W'(1);
                        state_q <= S_START;
                    end
                end
                S_START: begin
                    if (!rx_s) begin
                        if (cnt_q > CNT_W'(MAX_HI)) state_q <= S_IDLE;
                        else                        cnt_q   <= cnt_q + 1'b1;
                    end else if (match.hit) begin
                        width_q <= cnt_q;
                        cand_q  <= match.idx;
                        tmr_q   <= cnt_q >> 1;
                        bitn_q  <= '0;
                        state_q <= S_DATA;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_DATA: begin
                    if (tmr_q != '0) begin
                        tmr_q <= tmr_q - 1'b1;
                    end else if (bitn_q == 4'(LAST_BIT)) begin
                        if (rx_s) begin
                            locked_q <= 1'b1;
                            idx_q    <= cand_q;
                            div_q    <= nom_tab[cand_q];
                            state_q  <= S_LOCK;
                        end else begin
                            state_q  <= S_IDLE;
                        end
                    end else if (rx_s != CR_CHAR[bitn_q[2:0]]) begin
                        state_q <= S_IDLE;
                    end else begin
                        bitn_q <= bitn_q + 1'b1;
                        tmr_q  <= width_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign load_mode_o = load_q;
    assign locked_o    = locked_q;
    assign rate_idx_o  = idx_q;
    assign divisor_o   = div_q;

    // R8: leaving load mode drops the lock on the next clock
    p_exit_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !load_mode_o |=> !locked_o);

    // R7: locked values hold while load mode lasts
    p_hold_after_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (locked_o && load_mode_o) |=> ($stable(rate_idx_o) && $stable(divisor_o)));

    // R3: divisor agrees with the locked index
    p_div_matches_idx_r3: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (divisor_o == nom_tab[rate_idx_o]));

    // R6: lock only follows a high stop-bit sample in the data phase
    p_stop_high_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> ($past(rx_s) && $past(state_q == S_DATA)));

endmodule

// File: tb/tb_abd_top.sv
module tb_abd_top;
    import abd_pkg::*;

    localparam int unsigned CLK_HZ = 1_228_800;
    localparam int unsigned CNT_W  = $clog2(window_hi(CLK_HZ, NUM_RATES - 1) + 2);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rst_lvl_i = 1'b0;
    logic             strobe_n_i = 1'b1;
    logic [1:0]       addr_hi_i = 2'b11;
    logic             rxd_i = 1'b1;
    logic             load_mode_o;
    logic             locked_o;
    logic [1:0]       rate_idx_o;
    logic [CNT_W-1:0] divisor_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    abd_top #(.CLK_HZ(CLK_HZ)) dut (
        .clk         (clk),
        .rst         (rst),
        .rst_lvl_i   (rst_lvl_i),
        .strobe_n_i  (strobe_n_i),
        .addr_hi_i   (addr_hi_i),
        .rxd_i       (rxd_i),
        .load_mode_o (load_mode_o),
        .locked_o    (locked_o),
        .rate_idx_o  (rate_idx_o),
        .divisor_o   (divisor_o)
    );

    function automatic int unsigned exp_div(input int unsigned r);
        int unsigned b;
        b = (r == 0) ? 9600 : (r == 1) ? 2400 : (r == 2) ? 1200 : 300;
        return CLK_HZ / b;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] ch, input int p, input bit stop_ok);
        rxd_i = 1'b0; cyc(p);
        for (int i = 0; i < 8; i++) begin
            rxd_i = ch[i]; cyc(p);
        end
        rxd_i = stop_ok; cyc(p);
        rxd_i = 1'b1; cyc(20);
    endtask

    task automatic enter_load();
        rst_lvl_i = 1'b1; strobe_n_i = 1'b0; addr_hi_i = 2'b11; cyc(2);
    endtask

    task automatic leave_load();
        rst_lvl_i = 1'b0; cyc(2);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R9 reset state
        check("R9 load", load_mode_o, 0);
        check("R9 locked", locked_o, 0);
        check("R9 idx", rate_idx_o, 0);
        check("R9 div", divisor_o, 0);

        // R1 entry and qualifying conditions
        enter_load();
        check("R1 enter", load_mode_o, 1);
        strobe_n_i = 1'b1; cyc(2);
        check("R1 strobe high", load_mode_o, 0);
        strobe_n_i = 1'b0; cyc(2);
        check("R1 re-enter", load_mode_o, 1);

        // R2 parallel strap blocks serial load
        addr_hi_i = 2'b01; cyc(2);
        check("R2 load", load_mode_o, 0);
        send_frame(8'h0D, 128, 1'b1);
        check("R2 no lock", locked_o, 0);
        addr_hi_i = 2'b10; cyc(2);
        check("R2 bit6 low", load_mode_o, 0);
        addr_hi_i = 2'b11; cyc(2);

        // R4 out-of-window widths
        send_frame(8'h0D, 160, 1'b1); cyc(3000);
        check("R4 width 160", locked_o, 0);
        send_frame(8'h0D, 121, 1'b1); cyc(3000);
        check("R4 width 121", locked_o, 0);

        // R5 wrong character
        send_frame(8'h0F, 128, 1'b1); cyc(3000);
        check("R5 char 0F", locked_o, 0);
        send_frame(8'h8D, 128, 1'b1); cyc(3000);
        check("R5 char 8D", locked_o, 0);

        // R6 framing error then a good frame
        send_frame(8'h0D, 128, 1'b0); cyc(200);
        check("R6 framing", locked_o, 0);
        send_frame(8'h0D, 128, 1'b1);
        check("R6 lock", locked_o, 1);
        check("R3 idx 9600", rate_idx_o, 0);
        check("R3 div 9600", divisor_o, exp_div(0));

        // R7 stable under later traffic
        send_frame(8'h0D, 512, 1'b1);
        check("R7 idx", rate_idx_o, 0);
        check("R7 div", divisor_o, exp_div(0));

        // R8 exit clears
        leave_load();
        check("R8 load", load_mode_o, 0);
        check("R8 locked", locked_o, 0);
        check("R8 idx", rate_idx_o, 0);
        check("R8 div", divisor_o, 0);

        // R4 window edge: lowest accepted 9600 width
        enter_load();
        send_frame(8'h0D, 122, 1'b1);
        check("R4 edge 122", locked_o, 1);
        leave_load();

        // R3/R4 random rates with jitter inside the window
        for (int k = 0; k < 6; k++) begin
            int unsigned r;
            int          jit;
            int          p;
            r   = $urandom % 3;
            jit = int'($urandom % 9) - 4;
            p   = int'(exp_div(r)) * (100 + jit) / 100;
            enter_load();
            send_frame(8'h0D, p, 1'b1);
            check("R4 random lock", locked_o, 1);
            check("R3 random idx", rate_idx_o, r);
            check("R3 random div", divisor_o, exp_div(r));
            leave_load();
        end

        // R3 slowest rate
        enter_load();
        send_frame(8'h0D, 4096, 1'b1);
        check("R3 lock 300", locked_o, 1);
        check("R3 idx 300", rate_idx_o, 3);
        check("R3 div 300", divisor_o, exp_div(3));
        leave_load();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule